// File: doc/BRIEF.md
# Partial Store Byte Lane Generator

This block prepares the memory side of an unaligned "left" or "right" partial store of a 4-byte or 8-byte register. From the register value, the byte address, the store side, the access size and the core's byte order it works out which bytes of the register reach memory, the address each one lands on, and the order in which they go out. Two forms of the result are offered together. A combinational plan lists up to eight steps, each with an enable, a byte address and a data byte. A small sequencer latches that plan on a start pulse and plays it out one byte per cycle on a byte-write port, then flags completion.

The lane offset is the address reduced to the access alignment, mirrored when the core is little-endian. A left store begins with the register's top byte at the given address and walks toward lower-order register bytes. A right store begins with the bottom byte and walks toward higher-order ones. The walking direction in memory flips with byte order and with the store side. A left store and a right store at the same address therefore cover the whole access together, with one byte written by both.

Top module: `pst_lane_gen`

## Requirements
- R1: With N = 8 when `op_dword` is 1 and N = 4 otherwise, the offset is `op_addr[2:0] & (N-1)`, XORed with N-1 when `op_big` is 0. `lane_cnt` equals N minus the offset for a left store (`op_right` = 0) and the offset plus one for a right store (`op_right` = 1).
- R2: Step 0 is always enabled and targets `op_addr`. Its byte is register byte N-1 for a left store and register byte 0 for a right store (byte j is bits 8j+7 down to 8j).
- R3: Step k is placed at `op_addr` + k when byte order and side agree as (big, left) or (little, right), and at `op_addr` - k otherwise. Addresses wrap modulo 2^AW. Step k uses bits k*AW upward of `lane_addr`.
- R4: `lane_en` bit k is set for k < `lane_cnt` and clear otherwise, with no bit at or above N. Address and data of a disabled step read as zero.
- R5: Step k carries register byte N-1-k on a left store and register byte k on a right store, in `lane_data` bits 8k+7 down to 8k. For a 4-byte access, bits 63:32 of `op_value` have no effect.
- R6: For any address, size and byte order, the left count plus the right count equals N+1.
- R7: A start taken while `seq_ready` is 1 makes `wr_valid` rise in the next cycle with step 0. The enabled steps then follow in step order, one per cycle, without a gap.
- R8: In the cycle after the last byte, `seq_done` is 1 for exactly one cycle and `wr_valid` is 0. `seq_ready` is 1 while idle and while `seq_done` is 1.
- R9: A start raised while bytes are still being emitted is ignored. The running stream is not altered and no extra stream follows it.
- R10: A start raised in the `seq_done` cycle is taken, and the new stream's first byte appears in the next cycle.
- R11: During reset `wr_valid` and `seq_done` are 0 and `seq_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Request to emit the current plan |
| op_right | input | 1 | 1 for a right store, 0 for a left store |
| op_dword | input | 1 | 1 for an 8-byte access, 0 for 4-byte |
| op_big | input | 1 | 1 for big-endian, 0 for little-endian |
| op_addr | input | AW | Byte address of the store |
| op_value | input | 64 | Register value |
| lane_en | output | 8 | Enable per step |
| lane_cnt | output | 4 | Number of enabled steps |
| lane_addr | output | 8*AW | Byte address per step |
| lane_data | output | 64 | Data byte per step |
| seq_ready | output | 1 | Sequencer can take a start |
| wr_valid | output | 1 | Byte write present this cycle |
| wr_addr | output | AW | Byte write address |
| wr_byte | output | 8 | Byte write data |
| seq_done | output | 1 | One-cycle completion flag |

## Verification
Completion of one stream and acceptance of the next can coincide: `seq_done` is high in the very cycle a new start is sampled. The bench provokes this by chaining every store straight after the previous one's done cycle, and also runs stores separated by idle gaps. A scoreboard matches every emitted byte against a queue filled by the driver, and it checks that done arrives with the queue empty and right after a byte. A further check requires the new stream's first byte in the cycle after the chained start. A start pulse injected mid-stream has to leave the queue order intact.

// File: rtl/pst_lane_pkg.sv
package pst_lane_pkg;
  localparam int MAXB  = 8;
  localparam int OFFW  = $clog2(MAXB);
  localparam int CNTW  = OFFW + 1;
  localparam int DATAW = 8 * MAXB;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_FIN} seq_state_t;

  function automatic int access_bytes(input logic dword);
    return dword ? MAXB : MAXB / 2;
  endfunction

  // offset inside the aligned group, mirrored for little-endian
  function automatic logic [OFFW-1:0] lane_offset(input logic [OFFW-1:0] alo,
                                                  input logic dword,
                                                  input logic big);
    logic [OFFW-1:0] m;
    m = OFFW'(access_bytes(dword) - 1);
    return big ? (alo & m) : ((alo & m) ^ m);
  endfunction

  function automatic logic step_on(input logic right, input logic [OFFW-1:0] off,
                                  input int k, input logic dword);
    int n;
    n = access_bytes(dword);
    if (k >= n) return 1'b0;
    if (k == 0) return 1'b1;
    return right ? (int'(off) >= k) : (int'(off) + k <= n - 1);
  endfunction

  function automatic logic [CNTW-1:0] lane_total(input logic right,
                                                 input logic [OFFW-1:0] off,
                                                 input logic dword);
    return right ? (CNTW'(off) + CNTW'(1))
                 : (CNTW'(access_bytes(dword)) - CNTW'(off));
  endfunction

  function automatic logic [7:0] step_byte(input logic [DATAW-1:0] v, input logic right,
                                           input logic dword, input int k);
    int idx;
    idx = right ? k : access_bytes(dword) - 1 - k;
    return v[8*idx +: 8];
  endfunction
endpackage

// File: rtl/pst_lane_plan.sv
module pst_lane_plan
  import pst_lane_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_right,
  input  logic                  op_dword,
  input  logic                  op_big,
  input  logic [AW-1:0]         op_addr,
  input  logic [DATAW-1:0]      op_value,
  output logic [MAXB-1:0]       lane_en,
  output logic [MAXB*AW-1:0]    lane_addr,
  output logic [DATAW-1:0]      lane_data,
  output logic [CNTW-1:0]       lane_cnt,
  output logic                  lane_up
);
  logic [OFFW-1:0] off;

  assign off      = lane_offset(op_addr[OFFW-1:0], op_dword, op_big);
  assign lane_up  = op_big ^ op_right;
  assign lane_cnt = lane_total(op_right, off, op_dword);

  for (genvar g = 0; g < MAXB; g++) begin : g_step
    logic on;
    assign on = step_on(op_right, off, g, op_dword);
    assign lane_en[g] = on;
    assign lane_addr[g*AW +: AW] = !on ? '0 :
                                   lane_up ? (op_addr + AW'(g)) : (op_addr - AW'(g));
    assign lane_data[8*g +: 8] = on ? step_byte(op_value, op_right, op_dword, g) : 8'h00;
  end

  // enables and count come from separate functions; they must agree
  p_cnt_matches_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_en) == int'(lane_cnt));
  // enabled steps form a run starting at step 0
  p_first_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en[0] && (lane_addr[AW-1:0] == op_addr));
  p_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en & (lane_en + MAXB'(1))) == '0);
endmodule

// File: rtl/pst_byte_seq.sv
module pst_byte_seq
  import pst_lane_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [MAXB*AW-1:0] plan_addr,
  input  logic [DATAW-1:0]   plan_data,
  input  logic [CNTW-1:0]    plan_cnt,
  input  logic               plan_up,
  output logic               ready,
  output logic               wr_valid,
  output logic [AW-1:0]      wr_addr,
  output logic [7:0]         wr_byte,
  output logic               done
);
  seq_state_t           state_q;
  logic [MAXB*AW-1:0]   addr_q;
  logic [DATAW-1:0]     data_q;
  logic [CNTW-1:0]      cnt_q;
  logic [CNTW-1:0]      step_q;
  logic                 up_q;
  logic                 accept;
  logic                 last_step;

  assign ready     = (state_q != S_SEND);
  assign accept    = start && ready;
  assign wr_valid  = (state_q == S_SEND);
  assign done      = (state_q == S_FIN);
  assign last_step = wr_valid && (step_q == cnt_q - CNTW'(1));
  assign wr_addr   = wr_valid ? addr_q[int'(step_q[OFFW-1:0])*AW +: AW] : '0;
  assign wr_byte   = wr_valid ? data_q[8*int'(step_q[OFFW-1:0]) +: 8] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= CNTW'(1);
      step_q  <= '0;
      up_q    <= 1'b0;
    end else if (accept) begin
      state_q <= S_SEND;
      addr_q  <= plan_addr;
      data_q  <= plan_data;
      cnt_q   <= plan_cnt;
      step_q  <= '0;
      up_q    <= plan_up;
    end else begin
      case (state_q)
        S_SEND: begin
          if (last_step) state_q <= S_FIN;
          else           step_q  <= step_q + CNTW'(1);
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_addr_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !last_step |=>
      wr_addr == (up_q ? $past(wr_addr) + AW'(1) : $past(wr_addr) - AW'(1)));
  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !last_step |=> wr_valid);
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done && !wr_valid);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && ready |=> wr_valid);
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && wr_valid && !last_step |=> $stable(cnt_q) && $stable(up_q) && wr_valid);
endmodule

// File: rtl/pst_lane_gen.sv
module pst_lane_gen
  import pst_lane_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_start,
  input  logic               op_right,
  input  logic               op_dword,
  input  logic               op_big,
  input  logic [AW-1:0]      op_addr,
  input  logic [DATAW-1:0]   op_value,
  output logic [MAXB-1:0]    lane_en,
  output logic [CNTW-1:0]    lane_cnt,
  output logic [MAXB*AW-1:0] lane_addr,
  output logic [DATAW-1:0]   lane_data,
  output logic               seq_ready,
  output logic               wr_valid,
  output logic [AW-1:0]      wr_addr,
  output logic [7:0]         wr_byte,
  output logic               seq_done
);
  logic lane_up;

  pst_lane_plan #(.AW(AW)) u_plan (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_right  (op_right),
    .op_dword  (op_dword),
    .op_big    (op_big),
    .op_addr   (op_addr),
    .op_value  (op_value),
    .lane_en   (lane_en),
    .lane_addr (lane_addr),
    .lane_data (lane_data),
    .lane_cnt  (lane_cnt),
    .lane_up   (lane_up)
  );

  pst_byte_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (op_start),
    .plan_addr (lane_addr),
    .plan_data (lane_data),
    .plan_cnt  (lane_cnt),
    .plan_up   (lane_up),
    .ready     (seq_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_byte   (wr_byte),
    .done      (seq_done)
  );

  // sequencer emits nothing while idle or reporting completion
  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ready |-> !wr_valid);
endmodule

// File: tb/pst_lane_gen_bench.sv
`timescale 1ns/1ps
module pst_lane_gen_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 1'b0, op_right = 1'b0, op_dword = 1'b0, op_big = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [63:0]   op_value = '0;
  logic [7:0]    lane_en;
  logic [3:0]    lane_cnt;
  logic [8*AW-1:0] lane_addr;
  logic [63:0]   lane_data;
  logic          seq_ready, wr_valid, seq_done;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_byte;

  pst_lane_gen #(.AW(AW)) u_pst_lane_gen (.*);

  always #10 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [AW+7:0] exp_q[$];
  logic prev_valid = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      report();
      $finish;
    end
  end

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R9", "unexpected byte", {wr_addr, wr_byte}, 0);
        else begin
          logic [AW+7:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_byte} == e, "R7", "byte stream", {wr_addr, wr_byte}, e);
        end
      end
      if (seq_done) begin
        check(exp_q.size() == 0, "R8", "done with bytes pending", exp_q.size(), 0);
        check(prev_valid, "R8", "done not after last byte", prev_valid, 1);
      end
      prev_valid = wr_valid;
    end
  end

  // independent model: count, address and byte of each step
  function automatic int m_n(input logic d); return d ? 8 : 4; endfunction
  function automatic int m_cnt(input logic r, input logic d, input logic b, input logic [AW-1:0] a);
    int n, o;
    n = m_n(d);
    o = int'(a) % n;
    if (!b) o = n - 1 - o;
    return r ? o + 1 : n - o;
  endfunction
  function automatic logic [AW-1:0] m_addr(input logic r, input logic b, input logic [AW-1:0] a, input int k);
    bit up;
    up = (b && !r) || (!b && r);
    return up ? a + AW'(k) : a - AW'(k);
  endfunction
  function automatic logic [7:0] m_byte(input logic r, input logic d, input logic [63:0] v, input int k);
    int j;
    j = r ? k : m_n(d) - 1 - k;
    return 8'((v >> (8 * j)) & 64'hff);
  endfunction

  // drives inputs at a negedge and checks the combinational plan
  task automatic apply(input logic r, input logic d, input logic b,
                       input logic [AW-1:0] a, input logic [63:0] v);
    int c, c2;
    op_right = r; op_dword = d; op_big = b; op_addr = a; op_value = v;
    #1;
    c = m_cnt(r, d, b, a);
    check(int'(lane_cnt) == c, "R1", "lane count", lane_cnt, c);
    check(lane_en == 8'((1 << c) - 1), "R4", "enable mask", lane_en, (1 << c) - 1);
    check(lane_addr[AW-1:0] == a && lane_data[7:0] == m_byte(r, d, v, 0), "R2",
          "first step", {lane_addr[AW-1:0], lane_data[7:0]}, {a, m_byte(r, d, v, 0)});
    for (int k = 0; k < 8; k++) begin
      if (k < c) begin
        check(lane_addr[k*AW +: AW] == m_addr(r, b, a, k), "R3", "step address",
              lane_addr[k*AW +: AW], m_addr(r, b, a, k));
        check(lane_data[8*k +: 8] == m_byte(r, d, v, k), "R5", "step data",
              lane_data[8*k +: 8], m_byte(r, d, v, k));
      end else begin
        check(lane_addr[k*AW +: AW] == '0 && lane_data[8*k +: 8] == 8'h00, "R4",
              "disabled step not zero", {lane_addr[k*AW +: AW], lane_data[8*k +: 8]}, 0);
      end
    end
    op_right = !r; #1;
    c2 = int'(lane_cnt);
    check(c + c2 == m_n(d) + 1, "R6", "left plus right", c + c2, m_n(d) + 1);
    op_right = r; #1;
  endtask

  task automatic push_exp(input logic r, input logic d, input logic b,
                          input logic [AW-1:0] a, input logic [63:0] v);
    for (int k = 0; k < m_cnt(r, d, b, a); k++)
      exp_q.push_back({m_addr(r, b, a, k), m_byte(r, d, v, k)});
  endtask

  task automatic run_op(input logic r, input logic d, input logic b,
                        input logic [AW-1:0] a, input logic [63:0] v, input int gap);
    bit chained;
    apply(r, d, b, a, v);
    while (!seq_ready) @(negedge clk);
    #1;
    chained = seq_done;
    push_exp(r, d, b, a, v);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    if (chained) check(wr_valid, "R10", "start in done cycle not taken", wr_valid, 1);
    else         check(wr_valid, "R7", "first byte late", wr_valid, 1);
    while (!seq_done) @(negedge clk);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wr_valid && !seq_done && seq_ready, "R11", "reset outputs",
          {wr_valid, seq_done, seq_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    // every size, order, side and offset, chained and with gaps
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < 2; r++)
          for (int lo = 0; lo < m_n(1'(d)); lo++)
            run_op(1'(r), 1'(d), 1'(b), AW'(16'h4a30 + lo),
                   {$urandom, $urandom}, (lo == 2) ? 2 : 0);

    // R5: upper half ignored for 4-byte accesses
    run_op(1'b0, 1'b0, 1'b1, AW'(16'h0101), 64'hdead_beef_0403_0201, 1);
    run_op(1'b0, 1'b0, 1'b1, AW'(16'h0101), 64'h1234_5678_0403_0201, 1);

    // R9: start pulse while streaming must be ignored
    apply(1'b1, 1'b1, 1'b0, AW'(16'h7f00), 64'h0807_0605_0403_0201);
    #1;
    push_exp(1'b1, 1'b1, 1'b0, AW'(16'h7f00), 64'h0807_0605_0403_0201);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    @(negedge clk);
    op_right = 1'b0; op_addr = AW'(16'h0003); op_value = 64'hffff_ffff_ffff_ffff;
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    while (!seq_done) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check(!wr_valid, "R9", "extra stream after ignored start", wr_valid, 0);
    end

    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule